// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block connects a synchronous host to an external 512K x 8 asynchronous static RAM. The host hands over one word-wide request at a time on a valid/ready port, carrying a 19-bit address, an 8-bit write value and a direction flag. The controller then produces the memory's three active-low strobes (chip select, write strobe, output enable), holds the address steady, and drives or releases the data lines. A read returns its byte with a single-cycle valid pulse.

Every strobe interval is a whole number of clock cycles. Each count comes from a nanosecond minimum, divided by a clock-period parameter and rounded up. A read keeps chip select and output enable low for the full read cycle, and the byte is sampled on the edge that closes the access window. A write first waits out the memory's output float delay with output enable high. It then drives the data and pulls the write strobe low, and the write is ended by the rising write strobe. A short recovery follows. When no request is in flight, chip select is high, which leaves the memory in standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: Whenever req_ready is 1, no operation is in flight and mem_ce_n is 1 (standby).
- R3: A read accepted on a clock edge (req_valid=1, req_ready=1, req_write=0) holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for exactly ceil(max(70,35,70)/CLK_NS) cycles, starting in the cycle after acceptance. That is 7 cycles at 10 ns.
- R4: The read byte is sampled from mem_dq_in on the edge that ends the last cycle of the read window. rsp_valid is then 1 for exactly one cycle, with rsp_rdata holding that byte, and in that same cycle req_ready is 1.
- R5: A write (req_write=1) begins with ceil(25/CLK_NS) cycles (3 at 10 ns) of mem_ce_n=0, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0. This is the bus turnaround.
- R6: The write pulse then holds mem_we_n=0 and mem_dq_oe=1, with mem_dq_out equal to the accepted write byte, for ceil(max(50,30,60)/CLK_NS) cycles (6 at 10 ns). mem_we_n rises and mem_dq_oe falls on the same edge.
- R7: After the pulse, mem_ce_n stays 0 with mem_we_n=1 and mem_dq_oe=0 for max(1, ceil(70/CLK_NS) - turnaround - pulse) cycles (1 at 10 ns). mem_ce_n then returns to 1. A write never raises rsp_valid.
- R8: mem_addr equals the accepted req_addr from the cycle after acceptance until mem_ce_n returns to 1.
- R9: req_ready is 0 from acceptance until the operation ends. A request presented while req_ready is 0 is ignored: mem_addr and the strobe sequence are unchanged.
- R10: mem_dq_oe is never 1 while mem_oe_n is 0, mem_we_n is never 0 while mem_ce_n is 1, and mem_dq_oe rises only after mem_oe_n has been 1 for at least the turnaround count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Value for the data-line drivers |
| mem_dq_oe | output | 1 | Enable of the data-line drivers |
| mem_dq_in | input | 8 | Value read from the data lines |

## Verification
Two things can fall in the same cycle: the end of a read and the acceptance of the next request. The read-data pulse and the rising ready come out together, so a host that answers ready at once starts its next operation on the edge right after the returned byte. The bench provokes this by presenting each next request at the first instant ready is 1. It chains reads into writes and writes into reads this way. The scoreboard then has to see the correct byte in the same cycle that the following operation's turnaround or read window is checked cycle by cycle. A memory model returns a junk byte until the access window has fully elapsed, so sampling even one cycle early is caught.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_WTURN  = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WREST  = 3'd4
  } asram_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Recovery after the write strobe rises so the whole cycle meets its minimum.
  function automatic int unsigned rest_cycles(input int unsigned wc,
                                              input int unsigned turn,
                                              input int unsigned pulse);
    return (wc > turn + pulse) ? (wc - turn - pulse) : 1;
  endfunction

endpackage

// File: rtl/asram_cycle_counter.sv
module asram_cycle_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else            count <= count + 1'b1;
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned N_RD    = 7,
  parameter int unsigned N_CAP   = 7,
  parameter int unsigned N_TURN  = 3,
  parameter int unsigned N_PULSE = 6,
  parameter int unsigned N_REST  = 1,
  parameter int unsigned CNT_W   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_write,
  output asram_state_e state,
  output logic         phase_end,
  output logic         cap_now
);

  asram_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phase_len;
  logic             cnt_clear;

  always_comb begin
    unique case (state_q)
      ST_RD:     phase_len = CNT_W'(N_RD);
      ST_WTURN:  phase_len = CNT_W'(N_TURN);
      ST_WPULSE: phase_len = CNT_W'(N_PULSE);
      ST_WREST:  phase_len = CNT_W'(N_REST);
      default:   phase_len = CNT_W'(1);
    endcase
  end

  assign phase_end = (state_q != ST_IDLE) && (cnt == phase_len - 1'b1);
  assign cap_now   = (state_q == ST_RD) && (cnt == CNT_W'(N_CAP - 1));
  assign cnt_clear = (state_q == ST_IDLE) || phase_end;

  asram_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .count (cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = start_write ? ST_WTURN : ST_RD;
      ST_RD:     if (phase_end) state_d = ST_IDLE;
      ST_WTURN:  if (phase_end) state_d = ST_WPULSE;
      ST_WPULSE: if (phase_end) state_d = ST_WREST;
      ST_WREST:  if (phase_end) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (cnt < phase_len)); // R3
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_IDLE) || $past(phase_end)); // R9

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] din,
  output logic              vld,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      dout <= '0;
    end else begin
      vld <= cap;
      if (cap) dout <= din;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld); // R4

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS  = 70,
  parameter int unsigned T_AA_NS  = 70,
  parameter int unsigned T_DOE_NS = 35,
  parameter int unsigned T_WC_NS  = 70,
  parameter int unsigned T_PWE_NS = 50,
  parameter int unsigned T_SD_NS  = 30,
  parameter int unsigned T_AW_NS  = 60,
  parameter int unsigned T_HZ_NS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned N_CAP   = ns_to_cycles(max2(T_AA_NS, T_DOE_NS), CLK_NS);
  localparam int unsigned N_RD    = max2(ns_to_cycles(T_RC_NS, CLK_NS), N_CAP);
  localparam int unsigned N_TURN  = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int unsigned N_PULSE = ns_to_cycles(max2(max2(T_PWE_NS, T_SD_NS), T_AW_NS), CLK_NS);
  localparam int unsigned N_REST  = rest_cycles(ns_to_cycles(T_WC_NS, CLK_NS), N_TURN, N_PULSE);
  localparam int unsigned CNT_W   = $clog2(N_RD + N_TURN + N_PULSE + N_REST + 1);
  localparam int unsigned RUN_W   = CNT_W + 1;

  asram_state_e      state;
  logic              phase_end;
  logic              cap_now;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  asram_seq #(
    .N_RD    (N_RD),
    .N_CAP   (N_CAP),
    .N_TURN  (N_TURN),
    .N_PULSE (N_PULSE),
    .N_REST  (N_REST),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_write (req_write),
    .state       (state),
    .phase_end   (phase_end),
    .cap_now     (cap_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign mem_ce_n   = (state == ST_IDLE);
  assign mem_oe_n   = (state != ST_RD);
  assign mem_we_n   = (state != ST_WPULSE);
  assign mem_dq_oe  = (state == ST_WPULSE);
  assign mem_dq_out = wdata_q;
  assign mem_addr   = addr_q;

  asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap_now),
    .din   (mem_dq_in),
    .vld   (rsp_valid),
    .dout  (rsp_rdata)
  );

  // Saturating run lengths of strobe levels, kept for the timing assertions.
  logic [RUN_W-1:0] oe_high_run;
  logic [RUN_W-1:0] we_low_run;
  logic [RUN_W-1:0] rd_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_high_run <= '0;
      we_low_run  <= '0;
      rd_low_run  <= '0;
    end else begin
      oe_high_run <= !mem_oe_n ? '0 : (&oe_high_run ? oe_high_run : oe_high_run + 1'b1);
      we_low_run  <=  mem_we_n ? '0 : (&we_low_run  ? we_low_run  : we_low_run  + 1'b1);
      rd_low_run  <=  mem_oe_n ? '0 : (&rd_low_run  ? rd_low_run  : rd_low_run  + 1'b1);
    end
  end

  AST_STANDBY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n); // R2
  AST_READ_CAPTURE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rd_low_run == RUN_W'(N_RD))); // R4
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_run >= RUN_W'(N_PULSE))); // R6
  AST_WE_DQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $fell(mem_dq_oe)); // R6
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !rsp_valid); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R8
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R10
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R10
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_run >= RUN_W'(N_TURN))); // R10

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int B_RD    = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_TURN  = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_PULSE = (60 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_WC    = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_REST  = (B_WC > B_TURN + B_PULSE) ? B_WC - B_TURN - B_PULSE : 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_pins(input string req, input bit ce, input bit oe, input bit we, input bit dqoe);
    chk(req, {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, {28'd0, ce, oe, we, dqoe});
  endtask

  // Memory model: data valid only after the full access window with strobes active.
  logic [7:0]  mem [int];
  int          rd_age = 0;
  bit          wr_pend = 1'b0;
  logic [18:0] wr_a;
  logic [7:0]  wr_d;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      rd_age = rd_age + 1;
      mem_dq_in <= (rd_age >= B_RD) ? (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00) : 8'hEE;
    end else begin
      rd_age = 0;
      mem_dq_in <= 8'hEE;
    end
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      wr_pend = 1'b1; wr_a = mem_addr; wr_d = mem_dq_out;
    end else if (wr_pend && mem_we_n) begin
      mem[int'(wr_a)] = wr_d; wr_pend = 1'b0;
    end
  end

  // Scoreboard
  logic [7:0] exp_q [$];
  logic [7:0] shadow [int];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R4 unexpected rsp", 32'd1, 32'd0);
      else chk("R4 read data", {24'd0, rsp_rdata}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [18:0] a);
    exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    issue(1'b0, a, 8'h00);
    for (int i = 0; i < B_RD; i++) begin
      chk_pins("R3 read strobes", 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R8 read addr", {13'd0, mem_addr}, {13'd0, a});
      chk("R9 busy", {31'd0, req_ready}, 32'd0);
      chk("R4 no early rsp", {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
    end
    chk("R4 rsp pulse", {31'd0, rsp_valid}, 32'd1);
    chk("R4 ready with rsp", {31'd0, req_ready}, 32'd1);
    chk("R2 standby", {31'd0, mem_ce_n}, 32'd1);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d, input bit poke);
    shadow[int'(a)] = d;
    issue(1'b1, a, d);
    for (int i = 0; i < B_TURN + B_PULSE + B_REST; i++) begin
      if (poke && i == 1) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = a ^ 19'h55555;
      end
      if (poke && i == 3) req_valid = 1'b0;
      if (i < B_TURN)                chk_pins("R5 turnaround", 1'b0, 1'b1, 1'b1, 1'b0);
      else if (i < B_TURN + B_PULSE) begin
        chk_pins("R6 write pulse", 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R6 write data", {24'd0, mem_dq_out}, {24'd0, d});
      end else                       chk_pins("R7 recovery", 1'b0, 1'b1, 1'b1, 1'b0);
      chk(poke ? "R9 ignored addr" : "R8 write addr", {13'd0, mem_addr}, {13'd0, a});
      chk("R7 no rsp on write", {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
    end
    chk("R7 ce released", {31'd0, mem_ce_n}, 32'd1);
    chk("R9 ready after write", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_pins("R1 reset strobes", 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset rsp", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_pins("R1 idle after reset", 1'b1, 1'b1, 1'b1, 1'b0);

    do_write(19'h00012, 8'hA5, 1'b0);
    do_write(19'h7FFFF, 8'h3C, 1'b0);
    do_read(19'h00012);
    do_read(19'h7FFFF);
    do_write(19'h00000, 8'h5A, 1'b0);
    do_read(19'h00000);
    do_write(19'h2AAAA, 8'hC3, 1'b1);
    repeat (3) begin
      chk("R9 no extra op", {31'd0, mem_ce_n}, 32'd1);
      @(negedge clk);
    end
    do_read(19'h2AAAA);
    do_read(19'h12345);
    repeat (2) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 32'd0);
    chk("R2 final standby", {31'd0, mem_ce_n}, 32'd1);
    finish_run();
  end

endmodule